// File: doc/BRIEF.md
# SDRAM Per-Request Command Sequencer

This block turns one memory request into the shortest legal series of SDRAM commands for a four-bank device. An access request carries a bank, row, column, direction and burst length. The block issues one of three sequences. If the requested row is already open, it issues only the read or write. If the bank is idle, it issues an activate and then the access. If a different row is open, it issues a precharge of that bank, then an activate, then the access. A refresh request becomes a precharge of all banks followed by a refresh command.

The block records, for every bank, whether a row is open and which row it is. It times the gap from precharge to activate (`TRP_CYC`) and from activate to access (`TRCD_CYC`) with its own down-counters. All other spacing rules come from outside, as per-bank enable vectors plus single enables for precharge-all and refresh. A command leaves the block only in a cycle where its enable is high. Command outputs are combinational from the sequencer state and the enables, so a command is issued in the cycle it appears.

Requests use a valid/ready handshake. A request is captured only while the sequencer is idle. The requester holds `req_valid` until `req_ready`, and `req_ready` pulses in the cycle the final command of the sequence is issued.

Top module: `sdram_cmd_sequencer`

## Requirements
- R1: While `rst_n` is low, or for one cycle of `clr`, the sequencer returns to idle with no command and `req_ready` low, and every bank is marked closed. The next access to any bank is therefore activate then access.
- R2: An access to a closed bank issues an activate carrying the requested row, then the access.
- R3: An access to a bank whose open row equals the requested row issues only the read or write, in the first cycle after acceptance when its enable is high.
- R4: An access to a bank with a different row open issues precharge, activate and access, in that order, all to the requested bank.
- R5: The activate that follows a precharge is issued no earlier than `TRP_CYC` cycles after the precharge. With all enables high, it is issued exactly `TRP_CYC` cycles later.
- R6: The read or write that follows an activate is issued no earlier than `TRCD_CYC` cycles after the activate. With all enables high, it is issued exactly `TRCD_CYC` cycles later.
- R7: A command is issued only when its enable is high: bit `cmd_bank` of the matching per-bank vector, or the single enable for precharge-all and refresh. While that enable is low, the sequencer waits, and enables of other banks have no effect.
- R8: A refresh request issues precharge-all, then refresh, each gated by its own enable. Afterwards all banks are closed.
- R9: At most one command is issued per cycle. `req_ready` is high for exactly one cycle per request, the cycle in which the final read, write or refresh is issued.
- R10: `req_write`=1 selects a write (`cmd_wr`), 0 selects a read (`cmd_rd`). The column and the burst field (burst length minus one) are forwarded unchanged on `cmd_col` and `cmd_burst` with the access command.
- R11: A single-bank precharge closes only that bank, and rows open in other banks stay open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear, same effect as reset |
| req_valid | input | 1 | Request present, held until ready |
| req_refresh | input | 1 | 1 = refresh request, 0 = access |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_burst | input | BURST_W | Burst length minus one |
| req_ready | output | 1 | Pulses when the final command issues |
| en_pre | input | NUM_BANKS | Per-bank precharge enable |
| en_act | input | NUM_BANKS | Per-bank activate enable |
| en_rd | input | NUM_BANKS | Per-bank read enable |
| en_wr | input | NUM_BANKS | Per-bank write enable |
| en_pre_all | input | 1 | Precharge-all enable |
| en_refresh | input | 1 | Refresh enable |
| cmd_pre | output | 1 | Precharge of `cmd_bank` issued |
| cmd_act | output | 1 | Activate of `cmd_row` in `cmd_bank` issued |
| cmd_rd | output | 1 | Read issued |
| cmd_wr | output | 1 | Write issued |
| cmd_pre_all | output | 1 | Precharge-all issued |
| cmd_refresh | output | 1 | Refresh issued |
| cmd_bank | output | BANK_W | Bank of the current request |
| cmd_row | output | ROW_W | Row of the current request |
| cmd_col | output | COL_W | Column of the current request |
| cmd_burst | output | BURST_W | Burst field of the current request |

## Verification
The bench exercises the row-hit, idle-bank and row-miss paths and checks the exact issue cycle of each command. A sequencer that always precharged would show extra commands on a hit. One that skipped the precharge on a miss would activate a bank that is still open. A counter that was off by one, or that used the wrong delay, would move the activate or the access by a cycle. A single-bank precharge followed by a hit in another bank catches a tracker that clears too many flags. Enables held low for the target bank, while the other banks' enables stay high, expose a sequencer that fires early or that decodes the wrong enable bit. Refresh and clear followed by a previously open row show whether every bank was really closed.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the SDRAM per-request command sequencer.
package sdram_seq_pkg;

    // Sequencer states: one waiting state per command kind.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_ACC,
        ST_PALL,
        ST_REF
    } seq_state_t;

endpackage

// File: rtl/sdram_wait_counter.sv
// Down-counter for a fixed command-to-command delay.
// Loaded with DELAY-1 when the earlier command issues, so `done` rises
// exactly DELAY cycles after that command. Assumes DELAY >= 1.
module sdram_wait_counter #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    output logic done
);
    localparam int CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DELAY - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on the starting command, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // Delay of more than one cycle must block the follow-on command
    // in the next cycle (covers R5 for the precharge wait, R6 for activate).
    generate
        if (DELAY > 1) begin : g_gap
            p_gap_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
                load |=> !done);
        end
    endgenerate

endmodule

// File: rtl/sdram_bank_tracker.sv
// Open-row bookkeeping for every bank.
// An activate opens a bank on the given row, a single precharge closes
// only the addressed bank, and precharge-all or refresh closes all banks.
// Assumes at most one of the three update inputs is high per cycle.
module sdram_bank_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              open_en,
    input  logic                              close_en,
    input  logic                              close_all,
    input  logic [BANK_W-1:0]                 bank,
    input  logic [ROW_W-1:0]                  row,
    output logic [NUM_BANKS-1:0]              open_vec,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]   open_rows
);
    logic [NUM_BANKS-1:0]            open_q;
    logic [NUM_BANKS-1:0][ROW_W-1:0] rows_q;

    // Update the open flag and row of each bank from the issued command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            open_q <= '0;
            rows_q <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (close_all)
                    open_q[b] <= 1'b0;
                else if (close_en && bank == BANK_W'(b))
                    open_q[b] <= 1'b0;
                else if (open_en && bank == BANK_W'(b)) begin
                    open_q[b] <= 1'b1;
                    rows_q[b] <= row;
                end
            end
        end
    end

    assign open_vec  = open_q;
    assign open_rows = rows_q;

    generate
        for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
            p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
                (open_en && !close_all && bank == BANK_W'(i)) |=> (open_q[i] && rows_q[i] == $past(row)));
            p_pre_closes_one_r11: assert property (@(posedge clk) disable iff (!rst_n || clr)
                (close_en && bank == BANK_W'(i)) |=> !open_q[i]);
            p_pre_keeps_other_r11: assert property (@(posedge clk) disable iff (!rst_n || clr)
                (close_en && !close_all && bank != BANK_W'(i)) |=> (open_q[i] == $past(open_q[i])));
        end
    endgenerate

    p_all_closed_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
        close_all |=> (open_q == '0));

endmodule

// File: rtl/sdram_cmd_sequencer.sv
// Per-request SDRAM command sequencer.
// Captures one access or refresh request in idle and issues the shortest
// legal command series. Row state comes from sdram_bank_tracker. The
// precharge-to-activate and activate-to-access gaps come from two
// sdram_wait_counter instances. Every other spacing rule is assumed to be
// enforced by the external enables. Command outputs are combinational.
module sdram_cmd_sequencer
    import sdram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int BURST_W   = 2,
    parameter int TRP_CYC   = 3,
    parameter int TRCD_CYC  = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 req_valid,
    input  logic                 req_refresh,
    input  logic                 req_write,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic [BURST_W-1:0]   req_burst,
    output logic                 req_ready,
    input  logic [NUM_BANKS-1:0] en_pre,
    input  logic [NUM_BANKS-1:0] en_act,
    input  logic [NUM_BANKS-1:0] en_rd,
    input  logic [NUM_BANKS-1:0] en_wr,
    input  logic                 en_pre_all,
    input  logic                 en_refresh,
    output logic                 cmd_pre,
    output logic                 cmd_act,
    output logic                 cmd_rd,
    output logic                 cmd_wr,
    output logic                 cmd_pre_all,
    output logic                 cmd_refresh,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [ROW_W-1:0]     cmd_row,
    output logic [COL_W-1:0]     cmd_col,
    output logic [BURST_W-1:0]   cmd_burst
);
    seq_state_t state_q, state_d;

    logic               q_write;
    logic [BANK_W-1:0]  q_bank;
    logic [ROW_W-1:0]   q_row;
    logic [COL_W-1:0]   q_col;
    logic [BURST_W-1:0] q_burst;

    logic [NUM_BANKS-1:0]            open_vec;
    logic [NUM_BANKS-1:0][ROW_W-1:0] open_rows;
    logic trp_done, trcd_done;
    logic fire_pre, fire_act, fire_acc, fire_pall, fire_ref;
    logic acc_en;

    // Gate each pending command with its enable and the internal waits.
    always_comb begin
        acc_en    = q_write ? en_wr[q_bank] : en_rd[q_bank];
        fire_pre  = (state_q == ST_PRE)  && en_pre[q_bank];
        fire_act  = (state_q == ST_ACT)  && trp_done && en_act[q_bank];
        fire_acc  = (state_q == ST_ACC)  && trcd_done && acc_en;
        fire_pall = (state_q == ST_PALL) && en_pre_all;
        fire_ref  = (state_q == ST_REF)  && en_refresh;
    end

    // Pick the sequence on acceptance, then step on each issued command.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                if (req_refresh)
                    state_d = ST_PALL;
                else if (!open_vec[req_bank])
                    state_d = ST_ACT;
                else if (open_rows[req_bank] == req_row)
                    state_d = ST_ACC;
                else
                    state_d = ST_PRE;
            end
            ST_PRE:  if (fire_pre)  state_d = ST_ACT;
            ST_ACT:  if (fire_act)  state_d = ST_ACC;
            ST_ACC:  if (fire_acc)  state_d = ST_IDLE;
            ST_PALL: if (fire_pall) state_d = ST_REF;
            ST_REF:  if (fire_ref)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Hold the state and capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= ST_IDLE;
            q_write <= 1'b0;
            q_bank  <= '0;
            q_row   <= '0;
            q_col   <= '0;
            q_burst <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                q_write <= req_write;
                q_bank  <= req_bank;
                q_row   <= req_row;
                q_col   <= req_col;
                q_burst <= req_burst;
            end
        end
    end

    sdram_bank_tracker #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .open_en   (fire_act),
        .close_en  (fire_pre),
        .close_all (fire_pall || fire_ref),
        .bank      (q_bank),
        .row       (q_row),
        .open_vec  (open_vec),
        .open_rows (open_rows)
    );

    sdram_wait_counter #(.DELAY(TRP_CYC)) u_trp_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (fire_pre),
        .done  (trp_done)
    );

    sdram_wait_counter #(.DELAY(TRCD_CYC)) u_trcd_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (fire_act),
        .done  (trcd_done)
    );

    assign cmd_pre     = fire_pre;
    assign cmd_act     = fire_act;
    assign cmd_rd      = fire_acc && !q_write;
    assign cmd_wr      = fire_acc && q_write;
    assign cmd_pre_all = fire_pall;
    assign cmd_refresh = fire_ref;
    assign req_ready   = fire_acc || fire_ref;
    assign cmd_bank    = q_bank;
    assign cmd_row     = q_row;
    assign cmd_col     = q_col;
    assign cmd_burst   = q_burst;

    p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $onehot0({cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_pre_all, cmd_refresh}));
    p_act_on_closed_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
        cmd_act |-> !open_vec[cmd_bank]);
    p_pre_on_open_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
        cmd_pre |-> open_vec[cmd_bank]);
    p_access_row_open_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (cmd_rd || cmd_wr) |-> (open_vec[cmd_bank] && open_rows[cmd_bank] == cmd_row));
    p_refresh_all_closed_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
        cmd_refresh |-> (open_vec == '0));

endmodule

// File: tb/sdram_cmd_sequencer_bench.sv
module sdram_cmd_sequencer_bench;
    localparam int TRP  = 4;
    localparam int TRCD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        req_valid = 1'b0, req_refresh = 1'b0, req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [1:0]  req_burst = '0;
    logic        req_ready;
    logic [3:0]  en_pre = '1, en_act = '1, en_rd = '1, en_wr = '1;
    logic        en_pre_all = 1'b1, en_refresh = 1'b1;
    logic        cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_pre_all, cmd_refresh;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_row;
    logic [9:0]  cmd_col;
    logic [1:0]  cmd_burst;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Per-request observations (cycle index from the cycle valid is driven).
    int t_pre, t_act, t_acc, t_pall, t_ref, t_ready;
    int n_cmd, n_ready, n_multi, n_early, n_wrongbank;
    bit acc_was_wr;
    logic [9:0]  seen_col;
    logic [1:0]  seen_burst;
    logic [12:0] seen_row;

    always #2.5 clk = ~clk;

    sdram_cmd_sequencer #(
        .NUM_BANKS(4), .ROW_W(13), .COL_W(10), .BURST_W(2),
        .TRP_CYC(TRP), .TRCD_CYC(TRCD)
    ) u_sdram_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .req_valid(req_valid), .req_refresh(req_refresh), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_burst(req_burst),
        .req_ready(req_ready),
        .en_pre(en_pre), .en_act(en_act), .en_rd(en_rd), .en_wr(en_wr),
        .en_pre_all(en_pre_all), .en_refresh(en_refresh),
        .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_pre_all(cmd_pre_all), .cmd_refresh(cmd_refresh),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_burst(cmd_burst)
    );

    task automatic chk(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Drive one request; target-bank enables stay low before cycle `hold`.
    task automatic run_req(input bit rf, input bit wr, input logic [1:0] bk,
                           input logic [12:0] rw, input logic [9:0] cl,
                           input logic [1:0] bs, input int hold);
        int c;
        bit hung;
        t_pre = -1; t_act = -1; t_acc = -1; t_pall = -1; t_ref = -1; t_ready = -1;
        n_cmd = 0; n_ready = 0; n_multi = 0; n_early = 0; n_wrongbank = 0;
        acc_was_wr = 1'b0; seen_col = '0; seen_burst = '0; seen_row = '0;
        hung = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_refresh = rf; req_write = wr;
        req_bank = bk; req_row = rw; req_col = cl; req_burst = bs;
        c = 0;
        forever begin
            if (c > 0) @(negedge clk);
            en_pre     = (c >= hold) ? 4'hF : ~(4'b0001 << bk);
            en_act     = en_pre;
            en_rd      = en_pre;
            en_wr      = en_pre;
            en_pre_all = (c >= hold);
            en_refresh = (c >= hold);
            #1;
            if ($countones({cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_pre_all, cmd_refresh}) > 1)
                n_multi++;
            if (cmd_pre || cmd_act || cmd_rd || cmd_wr || cmd_pre_all || cmd_refresh) begin
                n_cmd++;
                if (c < hold) n_early++;
                if (!rf && cmd_bank != bk) n_wrongbank++;
            end
            if (cmd_pre && t_pre < 0) t_pre = c;
            if (cmd_act && t_act < 0) begin t_act = c; seen_row = cmd_row; end
            if ((cmd_rd || cmd_wr) && t_acc < 0) begin
                t_acc = c; acc_was_wr = cmd_wr; seen_col = cmd_col; seen_burst = cmd_burst;
            end
            if (cmd_pre_all && t_pall < 0) t_pall = c;
            if (cmd_refresh && t_ref < 0) t_ref = c;
            if (req_ready) begin
                n_ready++;
                t_ready = c;
                break;
            end
            c++;
            if (c > 200) begin hung = 1'b1; break; end
        end
        chk("R9 request completes", int'(hung), 0);
        @(negedge clk);
        req_valid = 1'b0;
        en_pre = '1; en_act = '1; en_rd = '1; en_wr = '1;
        en_pre_all = 1'b1; en_refresh = 1'b1;
    endtask

    task automatic test_reset_state();
        @(negedge clk); #1;
        chk("R1 ready low after reset", int'(req_ready), 0);
        chk("R1 no command after reset",
            $countones({cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_pre_all, cmd_refresh}), 0);
    endtask

    task automatic test_closed_write();
        run_req(1'b0, 1'b1, 2'd1, 13'h123, 10'h045, 2'd3, 0);
        chk("R2 no precharge on closed bank", t_pre, -1);
        chk("R2 activate cycle", t_act, 1);
        chk("R2 activate row", int'(seen_row), 'h123);
        chk("R6 access after TRCD", t_acc, 1 + TRCD);
        chk("R10 write selected", int'(acc_was_wr), 1);
        chk("R10 column forwarded", int'(seen_col), 'h045);
        chk("R10 burst forwarded", int'(seen_burst), 3);
        chk("R9 ready once", n_ready, 1);
        chk("R9 ready on final command", t_ready, t_acc);
        chk("R9 one command per cycle", n_multi, 0);
    endtask

    task automatic test_row_hit();
        run_req(1'b0, 1'b0, 2'd1, 13'h123, 10'h3FF, 2'd0, 0);
        chk("R3 access only count", n_cmd, 1);
        chk("R3 access cycle", t_acc, 1);
        chk("R10 read selected", int'(acc_was_wr), 0);
        chk("R10 burst zero forwarded", int'(seen_burst), 0);
    endtask

    task automatic test_row_miss();
        run_req(1'b0, 1'b1, 2'd1, 13'h777, 10'h001, 2'd1, 0);
        chk("R4 precharge cycle", t_pre, 1);
        chk("R5 activate after TRP", t_act, 1 + TRP);
        chk("R6 access after TRCD", t_acc, 1 + TRP + TRCD);
        chk("R4 three commands", n_cmd, 3);
        chk("R4 all on requested bank", n_wrongbank, 0);
        chk("R4 activate row", int'(seen_row), 'h777);
    endtask

    task automatic test_other_bank_kept();
        run_req(1'b0, 1'b0, 2'd2, 13'h010, 10'h0, 2'd0, 0);
        chk("R2 bank2 opened with activate", t_act, 1);
        run_req(1'b0, 1'b0, 2'd1, 13'h020, 10'h0, 2'd0, 0);
        chk("R11 miss on bank1 precharges", t_pre, 1);
        run_req(1'b0, 1'b1, 2'd2, 13'h010, 10'h0, 2'd2, 0);
        chk("R11 bank2 still open after bank1 precharge", n_cmd, 1);
        chk("R11 bank2 hit access cycle", t_acc, 1);
    endtask

    task automatic test_enable_gating();
        run_req(1'b0, 1'b0, 2'd2, 13'h011, 10'h0, 2'd0, 6);
        chk("R7 no command while enable low", n_early, 0);
        chk("R7 precharge waits for enable", t_pre, 6);
        chk("R5 activate after TRP under gating", t_act, 6 + TRP);
        chk("R6 access after TRCD under gating", t_acc, 6 + TRP + TRCD);
        run_req(1'b0, 1'b0, 2'd3, 13'h005, 10'h0, 2'd0, 3);
        chk("R7 activate waits for enable", t_act, 3);
        chk("R7 access after gated activate", t_acc, 3 + TRCD);
    endtask

    task automatic test_refresh();
        run_req(1'b1, 1'b0, 2'd0, 13'h0, 10'h0, 2'd0, 0);
        chk("R8 precharge-all cycle", t_pall, 1);
        chk("R8 refresh cycle", t_ref, 2);
        chk("R9 ready on refresh", t_ready, 2);
        chk("R8 only two commands", n_cmd, 2);
        run_req(1'b0, 1'b0, 2'd2, 13'h011, 10'h0, 2'd0, 0);
        chk("R8 bank closed after refresh", t_act, 1);
        chk("R8 no precharge after refresh", t_pre, -1);
        run_req(1'b1, 1'b0, 2'd0, 13'h0, 10'h0, 2'd0, 4);
        chk("R7 precharge-all waits for enable", t_pall, 4);
        chk("R7 refresh after gated precharge-all", t_ref, 5);
    endtask

    task automatic test_clear();
        run_req(1'b0, 1'b1, 2'd3, 13'h0AB, 10'h0, 2'd0, 0);
        @(negedge clk); clr = 1'b1;
        #1;
        @(negedge clk); clr = 1'b0;
        run_req(1'b0, 1'b1, 2'd3, 13'h0AB, 10'h0, 2'd0, 0);
        chk("R1 bank closed after clear", t_pre, -1);
        chk("R1 activate after clear", t_act, 1);
        chk("R1 access after clear", t_acc, 1 + TRCD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_state();
        test_closed_write();
        test_row_hit();
        test_row_miss();
        test_other_bank_kept();
        test_enable_gating();
        test_refresh();
        test_clear();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule